// File: doc/BRIEF.md
# Loopback Self-Test Sequencer for a Serial Port

This block drives a built-in self test of a byte-wide asynchronous serial port. A start pulse makes it request loopback, so that the port's receive input is fed from its own transmit output. It then pushes a run of pseudo-random bytes into the transmit queue, with each byte taken from an 8-bit shift-register generator. Once the last byte has been written, it reloads the generator with the same seed. It then reads the received bytes back from the receive queue and compares each one against the regenerated sequence.

The outcome is kept in an 8-bit result register. Bit 0 is the overall pass flag. Bits 1 to 3 name the kind of failure: a data mismatch, a receiver error, or a timeout. Bit 7 marks that the run has finished. The register keeps its value until the next start. The generator is reseeded on every start, so every run sends an identical byte sequence.

Top module: `bist_loop_ctrl`

## Requirements
- R1: After reset, `status_o` is 0x00, `done_o` and `loop_en_o` are 0, and neither `tx_wr_o` nor `rx_rd_o` is asserted.
- R2: A high `start_i` sampled while the block is not running clears `status_o` to 0x00 and starts a run. `loop_en_o` is 1 from the cycle after that edge until the run finishes.
- R3: A run writes exactly NUM_PAT (default 16) bytes. The first byte is SEED (default 0xA5), and each following byte is derived from the previous byte p as {p[6:0], p[7]^p[5]^p[4]^p[3]}. `tx_wr_o` is never high while `tx_full_i` is high.
- R4: After the last write, the block pops one byte whenever `rx_empty_i` is low, taking `rx_data_i` as the head byte, and compares it with the same sequence regenerated from SEED. Any difference sets status bit 1. `rx_rd_o` is never high while `rx_empty_i` is high.
- R5: If `rx_err_i` is high in any running cycle, status bit 2 is set.
- R6: If the NUM_PAT bytes have not all been popped within TIMEOUT_CYC (default 4096) running cycles, status bit 3 is set and the run ends with no further strobes.
- R7: When a run ends, status bit 7 is set. Bit 0 is set if and only if bits 1 to 3 are all clear. `done_o` follows bit 7, `loop_en_o` falls, and `status_o` holds until the next start. Bits 4 to 6 are always 0.
- R8: `start_i` has no effect while a run is in progress. The run still writes NUM_PAT bytes and ends with the same result it would have had without that pulse.
- R9: Each start reseeds the generator, so back-to-back runs send identical byte sequences.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| start_i | input | 1 | begins a self-test run when idle |
| tx_full_i | input | 1 | transmit queue full |
| tx_wr_o | output | 1 | write strobe to the transmit queue |
| tx_data_o | output | 8 | pattern byte to write |
| rx_empty_i | input | 1 | receive queue empty |
| rx_data_i | input | 8 | head byte of the receive queue |
| rx_rd_o | output | 1 | pop strobe to the receive queue |
| rx_err_i | input | 1 | any receiver error flag (parity, framing, overrun, break) |
| loop_en_o | output | 1 | selects transmit output as receive input |
| done_o | output | 1 | run finished |
| status_o | output | 8 | result register |

## Verification
A generator that steps at the wrong time, or is not reloaded between the two phases, shows up straight away. The written bytes no longer match the sequence computed from SEED, and the finished status reads 0x82 instead of 0x81. A sticky flag that is lost or cleared too early shows up as a wrong status once the run ends, which is about 35 cycles after start when the queues never stall. A miscounted byte total shows up as a wrong number of writes, or as a false timeout after TIMEOUT_CYC cycles. A faulty start guard shows up as a restarted sequence or a cleared register in the middle of a run.

// File: rtl/bist_loop_pkg.sv
package bist_loop_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_RECV = 2'd2,
    ST_FIN  = 2'd3
  } bist_state_e;

  localparam int unsigned BIT_PASS = 0;
  localparam int unsigned BIT_MISM = 1;
  localparam int unsigned BIT_RXER = 2;
  localparam int unsigned BIT_TOUT = 3;
  localparam int unsigned BIT_DONE = 7;
endpackage

// File: rtl/bist_lfsr.sv
module bist_lfsr #(
  parameter int unsigned W    = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'hA5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic         step_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] q;
  logic         fb;

  assign fb    = ^(q & TAPS);
  assign val_o = q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= SEED;
    else if (step_i) q <= {q[W-2:0], fb};
  end

  AST_LFSR_NONZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q != '0);  // R3
endmodule

// File: rtl/bist_timer.sv
module bist_timer #(
  parameter int unsigned LIMIT = 4096,
  localparam int unsigned CW   = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic run_i,
  output logic expire_o
);
  logic [CW-1:0] cnt;

  assign expire_o = run_i && (cnt == CW'(LIMIT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt <= '0;
    else if (clr_i)              cnt <= '0;
    else if (run_i && !expire_o) cnt <= cnt + 1'b1;
  end

  AST_TIMER_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt < CW'(LIMIT));  // R6
endmodule

// File: rtl/bist_loop_ctrl.sv
module bist_loop_ctrl
  import bist_loop_pkg::*;
#(
  parameter int unsigned    NUM_PAT     = 16,
  parameter int unsigned    TIMEOUT_CYC = 4096,
  parameter logic [7:0]     SEED        = 8'hA5,
  localparam int unsigned   NW          = $clog2(NUM_PAT + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       tx_full_i,
  output logic       tx_wr_o,
  output logic [7:0] tx_data_o,
  input  logic       rx_empty_i,
  input  logic [7:0] rx_data_i,
  output logic       rx_rd_o,
  input  logic       rx_err_i,
  output logic       loop_en_o,
  output logic       done_o,
  output logic [7:0] status_o
);
  bist_state_e st_q;
  logic [NW-1:0] wr_cnt_q, rd_cnt_q;
  logic [7:0]    stat_q;
  logic [7:0]    pat;
  logic          tmo, running, last_wr, last_rd, lfsr_load, lfsr_step;

  assign running   = (st_q == ST_SEND) || (st_q == ST_RECV);
  assign tx_wr_o   = (st_q == ST_SEND) && !tx_full_i && !tmo;
  assign rx_rd_o   = (st_q == ST_RECV) && !rx_empty_i && !tmo;
  assign last_wr   = tx_wr_o && (wr_cnt_q == NW'(NUM_PAT - 1));
  assign last_rd   = rx_rd_o && (rd_cnt_q == NW'(NUM_PAT - 1));
  // reload the seed at start and again to regenerate for comparison
  assign lfsr_load = ((st_q == ST_IDLE) && start_i) || last_wr;
  assign lfsr_step = tx_wr_o || rx_rd_o;
  assign tx_data_o = pat;
  assign loop_en_o = running;
  assign status_o  = stat_q;
  assign done_o    = stat_q[BIT_DONE];

  bist_lfsr #(.W(8), .TAPS(8'hB8), .SEED(SEED)) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (lfsr_load),
    .step_i (lfsr_step),
    .val_o  (pat)
  );

  bist_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q == ST_IDLE),
    .run_i    (running),
    .expire_o (tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      wr_cnt_q <= '0;
      rd_cnt_q <= '0;
      stat_q   <= '0;
    end else begin
      if (running && rx_err_i) stat_q[BIT_RXER] <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q     <= ST_SEND;
          stat_q   <= '0;
          wr_cnt_q <= '0;
          rd_cnt_q <= '0;
        end
        ST_SEND: begin
          if (tmo) begin
            stat_q[BIT_TOUT] <= 1'b1;
            st_q             <= ST_FIN;
          end else if (tx_wr_o) begin
            wr_cnt_q <= wr_cnt_q + 1'b1;
            if (last_wr) st_q <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (tmo) begin
            stat_q[BIT_TOUT] <= 1'b1;
            st_q             <= ST_FIN;
          end else if (rx_rd_o) begin
            rd_cnt_q <= rd_cnt_q + 1'b1;
            if (rx_data_i != pat) stat_q[BIT_MISM] <= 1'b1;
            if (last_rd) st_q <= ST_FIN;
          end
        end
        ST_FIN: begin
          stat_q[BIT_DONE] <= 1'b1;
          stat_q[BIT_PASS] <= ~|stat_q[BIT_TOUT:BIT_MISM];
          st_q             <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_NO_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_wr_o |-> !tx_full_i);  // R3
  AST_NO_RD_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_rd_o |-> !rx_empty_i);  // R4
  AST_WR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_cnt_q <= NW'(NUM_PAT));  // R3
  AST_PASS_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> (status_o[BIT_PASS] == !(|status_o[BIT_TOUT:BIT_MISM])));  // R7
  AST_LOOP_NOT_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_o |-> !done_o);  // R2
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_o |-> (!tx_wr_o && !rx_rd_o));  // R7
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> $stable(status_o));  // R7
endmodule

// File: tb/bist_loop_ctrl_tb_top.sv
module bist_loop_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT = 16;
  localparam logic [7:0] SEED = 8'hA5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, tx_full_i = 1'b0, rx_empty_i, rx_err_i = 1'b0;
  logic [7:0] rx_data_i;
  logic tx_wr_o, rx_rd_o, loop_en_o, done_o;
  logic [7:0] tx_data_o, status_o;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic [7:0] txlog[$];
  logic [7:0] rxq[$];
  logic wr_seen = 0, rd_seen = 0;
  logic [7:0] wr_byte = 0;
  int wr_full_viol = 0, rd_empty_viol = 0;
  bit stall_mode = 0, drop_last = 0;
  int corrupt_idx = -1, err_idx = -1;

  always #(CLK_PERIOD/2) clk = ~clk;

  bist_loop_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start_i),
    .tx_full_i(tx_full_i), .tx_wr_o(tx_wr_o), .tx_data_o(tx_data_o),
    .rx_empty_i(rx_empty_i), .rx_data_i(rx_data_i), .rx_rd_o(rx_rd_o),
    .rx_err_i(rx_err_i), .loop_en_o(loop_en_o), .done_o(done_o),
    .status_o(status_o)
  );

  assign rx_empty_i = (rxq.size() == 0);
  assign rx_data_i  = (rxq.size() != 0) ? rxq[0] : 8'h00;

  always @(posedge clk) begin
    cyc++;
    wr_seen = tx_wr_o;
    wr_byte = tx_data_o;
    rd_seen = rx_rd_o;
    if (tx_wr_o && tx_full_i) wr_full_viol++;
    if (rx_rd_o && rx_empty_i) rd_empty_viol++;
  end

  // loopback queue model, updated away from the active edge
  always @(negedge clk) begin
    if (rd_seen && rxq.size() != 0) void'(rxq.pop_front());
    if (wr_seen) begin
      txlog.push_back(wr_byte);
      if (!(drop_last && txlog.size() == NPAT))
        rxq.push_back((txlog.size() - 1 == corrupt_idx) ? (wr_byte ^ 8'h10) : wr_byte);
    end
    rx_err_i  <= (err_idx >= 0 && txlog.size() == err_idx && wr_seen);
    tx_full_i <= stall_mode && loop_en_o && ((cyc % 3) != 0);
    wr_seen = 0;
    rd_seen = 0;
  end

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return {p[6:0], p[7] ^ p[5] ^ p[4] ^ p[3]};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk);
    txlog.delete();
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done_o && n < 6000) begin @(negedge clk); n++; end
  endtask

  task automatic check_seq(input string tag);
    logic [7:0] e = SEED;
    bit ok = (txlog.size() == NPAT);
    int bad_i = -1;
    check(txlog.size() == NPAT, {tag, " write count"}, txlog.size(), NPAT);
    for (int i = 0; i < txlog.size(); i++) begin
      if (txlog[i] != e && bad_i < 0) begin bad_i = i; ok = 0; end
      e = nxt(e);
    end
    check(ok, {tag, " byte sequence"}, bad_i, -1);
  endtask

  task automatic t_reset();
    check(status_o == 8'h00, "R1 status", status_o, 0);
    check(!done_o && !loop_en_o && !tx_wr_o && !rx_rd_o, "R1 outputs",
          {done_o, loop_en_o, tx_wr_o, rx_rd_o}, 0);
  endtask

  task automatic t_clean();
    pulse_start();
    check(loop_en_o && status_o == 8'h00, "R2 loop on, status cleared",
          {loop_en_o, status_o}, 9'h100);
    wait_done();
    check(status_o == 8'h81, "R7 clean pass status", status_o, 8'h81);
    check(!loop_en_o, "R7 loop released", loop_en_o, 0);
    check_seq("R3");
    repeat (5) @(negedge clk);
    check(status_o == 8'h81 && done_o, "R7 status held", status_o, 8'h81);
  endtask

  task automatic t_stall();
    stall_mode = 1;
    pulse_start();
    wait_done();
    stall_mode = 0;
    check(wr_full_viol == 0, "R3 no write while full", wr_full_viol, 0);
    check(rd_empty_viol == 0, "R4 no read while empty", rd_empty_viol, 0);
    check(status_o == 8'h81, "R3 stalled run passes", status_o, 8'h81);
    check_seq("R9 stalled rerun");
  endtask

  task automatic t_mismatch();
    corrupt_idx = 9;
    pulse_start();
    wait_done();
    corrupt_idx = -1;
    check(status_o == 8'h82, "R4 mismatch flagged", status_o, 8'h82);
  endtask

  task automatic t_rxerr();
    err_idx = 5;
    pulse_start();
    wait_done();
    err_idx = -1;
    check(status_o == 8'h84, "R5 receiver error flagged", status_o, 8'h84);
  endtask

  task automatic t_timeout();
    drop_last = 1;
    pulse_start();
    wait_done();
    drop_last = 0;
    check(status_o == 8'h88, "R6 timeout flagged", status_o, 8'h88);
    repeat (3) @(negedge clk);
    check(!tx_wr_o && !rx_rd_o && !loop_en_o, "R6 quiet after timeout",
          {tx_wr_o, rx_rd_o, loop_en_o}, 0);
  endtask

  task automatic t_restart_ignored();
    pulse_start();
    repeat (20) @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(loop_en_o && status_o == 8'h00, "R8 run continues", {loop_en_o, status_o}, 9'h100);
    wait_done();
    check(status_o == 8'h81, "R8 result unchanged", status_o, 8'h81);
    check_seq("R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_clean();
    t_stall();
    t_mismatch();
    t_rxerr();
    t_timeout();
    t_restart_ignored();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule